// File: doc/BRIEF.md
# Enabled-Bit Compaction Unit

The block takes a 32-bit data vector and a 32-bit enable mask of the same width. Every data bit whose enable is set is gathered, and the gathered bits are packed side by side into a 16-bit output word. The packing starts at output bit 0 and takes the enabled bits from the lowest index upward. Once sixteen bits have been placed, any further enabled bits are dropped. Output positions that nothing fills read as zero.

The block computes the packed word, the number of bits placed and an overflow flag in one combinational step. It captures all three in a single register stage on the rising clock edge. A new data and mask pair can be presented on every cycle, and its result appears one cycle later. A typical use is to extract a sparse set of flags or lanes from a wide status vector into a dense field.

Top module: `bit_compactor`

## Requirements
- R1: Data bit i with its enable set lands at output position k, where k is the number of enable bits set at indices below i. Output bit 0 holds the lowest-index enabled bit.
- R2: When more than 16 enable bits are set, only the 16 enabled bits with the lowest indices are placed. Higher-index enabled bits do not appear in the output.
- R3: When fewer than 16 enable bits are set, every output position at or above the placed count is 0.
- R4: All outputs are registered. A data and mask pair presented before a rising edge shows at the outputs right after that edge, and the outputs hold their old value until then.
- R5: A synchronous active-high reset clears the packed word, the count and the overflow flag to 0 at the next rising edge.
- R6: The overflow flag is 1 exactly when more than 16 enable bits are set. With exactly 16 enable bits set it is 0.
- R7: The count output equals the number of set enable bits, saturated at 16. It is 5 bits wide.
- R8: A data bit whose enable is clear has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 32 | Source data vector |
| en_mask | input | 32 | Per-bit select mask, 1 = take the bit |
| packed_out | output | 16 | Compacted word, registered |
| placed_cnt | output | 5 | Number of bits placed, saturating at 16, registered |
| overflow | output | 1 | More than 16 enable bits were set, registered |

## Verification
The assertions assume only that the data and mask inputs are known (0 or 1) at each rising edge outside reset. They compare the count and the overflow flag against the mask sampled one cycle earlier. The bench changes its inputs only on falling edges, so every rising edge samples settled values. Its random masks are shaped by ANDing or ORing several draws, which gives sparse, medium and dense masks. Directed cases supply exactly 15, 16 and 17 set enables, an all-zero mask and an all-ones mask.

// File: rtl/bitpack_pkg.sv
package bitpack_pkg;
  localparam int DEF_IN_W  = 32;
  localparam int DEF_OUT_W = 16;

  function automatic int rank_width(input int in_w);
    return $clog2(in_w + 1);
  endfunction
endpackage

// File: rtl/bc_rank.sv
module bc_rank #(
  parameter int IN_W = bitpack_pkg::DEF_IN_W,
  localparam int RW  = bitpack_pkg::rank_width(IN_W)
) (
  input  logic [IN_W-1:0]          en,
  output logic [IN_W-1:0][RW-1:0]  rank,
  output logic [RW-1:0]            total
);
  // rank[i] counts the enabled positions strictly below i
  assign rank[0] = '0;
  for (genvar i = 1; i < IN_W; i++) begin : g_prefix
    assign rank[i] = rank[i-1] + RW'(en[i-1]);
  end
  assign total = rank[IN_W-1] + RW'(en[IN_W-1]);
endmodule

// File: rtl/bc_pack.sv
module bc_pack #(
  parameter int IN_W  = bitpack_pkg::DEF_IN_W,
  parameter int OUT_W = bitpack_pkg::DEF_OUT_W,
  localparam int RW   = bitpack_pkg::rank_width(IN_W)
) (
  input  logic [IN_W-1:0]          din,
  input  logic [IN_W-1:0]          en,
  input  logic [IN_W-1:0][RW-1:0]  rank,
  output logic [OUT_W-1:0]         word
);
  // each output slot selects the single enabled input whose rank matches it;
  // inputs ranked OUT_W or beyond match no slot and fall away
  for (genvar k = 0; k < OUT_W; k++) begin : g_slot
    logic [IN_W-1:0] hit;
    for (genvar i = 0; i < IN_W; i++) begin : g_src
      assign hit[i] = en[i] && (rank[i] == RW'(k)) && din[i];
    end
    assign word[k] = |hit;
  end
endmodule

// File: rtl/bc_outreg.sv
module bc_outreg #(
  parameter int IN_W  = bitpack_pkg::DEF_IN_W,
  parameter int OUT_W = bitpack_pkg::DEF_OUT_W,
  localparam int RW   = bitpack_pkg::rank_width(IN_W),
  localparam int CW   = $clog2(OUT_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OUT_W-1:0] word,
  input  logic [RW-1:0]    total,
  output logic [OUT_W-1:0] q_word,
  output logic [CW-1:0]    q_cnt,
  output logic             q_ov
);
  logic            too_many;
  logic [CW-1:0]   sat_cnt;

  assign too_many = total > RW'(OUT_W);
  assign sat_cnt  = too_many ? CW'(OUT_W) : CW'(total);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_word <= '0;
      q_cnt  <= '0;
      q_ov   <= 1'b0;
    end else begin
      q_word <= word;
      q_cnt  <= sat_cnt;
      q_ov   <= too_many;
    end
  end
endmodule

// File: rtl/bit_compactor.sv
module bit_compactor #(
  parameter int IN_W  = bitpack_pkg::DEF_IN_W,
  parameter int OUT_W = bitpack_pkg::DEF_OUT_W,
  localparam int RW   = bitpack_pkg::rank_width(IN_W),
  localparam int CW   = $clog2(OUT_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  data_in,
  input  logic [IN_W-1:0]  en_mask,
  output logic [OUT_W-1:0] packed_out,
  output logic [CW-1:0]    placed_cnt,
  output logic             overflow
);
  logic [IN_W-1:0][RW-1:0] rank;
  logic [RW-1:0]           total;
  logic [OUT_W-1:0]        word;

  bc_rank #(.IN_W(IN_W)) u_rank (
    .en    (en_mask),
    .rank  (rank),
    .total (total)
  );

  bc_pack #(.IN_W(IN_W), .OUT_W(OUT_W)) u_pack (
    .din  (data_in),
    .en   (en_mask),
    .rank (rank),
    .word (word)
  );

  bc_outreg #(.IN_W(IN_W), .OUT_W(OUT_W)) u_outreg (
    .clk    (clk),
    .rst    (rst),
    .word   (word),
    .total  (total),
    .q_word (packed_out),
    .q_cnt  (placed_cnt),
    .q_ov   (overflow)
  );
endmodule

// File: rtl/bc_checker.sv
module bc_checker #(
  parameter int IN_W  = bitpack_pkg::DEF_IN_W,
  parameter int OUT_W = bitpack_pkg::DEF_OUT_W,
  localparam int CW   = $clog2(OUT_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [IN_W-1:0]  en_mask,
  input logic [OUT_W-1:0] packed_out,
  input logic [CW-1:0]    placed_cnt,
  input logic             overflow
);
  function automatic logic [CW-1:0] sat_pop(input logic [IN_W-1:0] m);
    int n;
    n = $countones(m);
    return (n > OUT_W) ? CW'(OUT_W) : CW'(n);
  endfunction

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (packed_out == '0) && (placed_cnt == '0) && !overflow);

  // R7
  count_track_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> placed_cnt == sat_pop($past(en_mask)));

  // R6
  overflow_track_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> overflow == ($countones($past(en_mask)) > OUT_W));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (placed_cnt < CW'(OUT_W)) |-> ((packed_out >> placed_cnt) == '0));

  // R1
  ones_bound_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(packed_out) <= int'(placed_cnt));
endmodule

bind bit_compactor bc_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_mask    (en_mask),
  .packed_out (packed_out),
  .placed_cnt (placed_cnt),
  .overflow   (overflow)
);

// File: tb/bit_compactor_bench.sv
`timescale 1ns/1ps
module bit_compactor_bench;
  localparam int IN_W  = 32;
  localparam int OUT_W = 16;
  localparam int CW    = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [IN_W-1:0]  data_in = '0;
  logic [IN_W-1:0]  en_mask = '0;
  logic [OUT_W-1:0] packed_out;
  logic [CW-1:0]    placed_cnt;
  logic             overflow;

  int  n_vec  = 0;
  int  n_bad  = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  bit_compactor #(.IN_W(IN_W), .OUT_W(OUT_W)) u_bit_compactor (
    .clk(clk), .rst(rst), .data_in(data_in), .en_mask(en_mask),
    .packed_out(packed_out), .placed_cnt(placed_cnt), .overflow(overflow)
  );

  // expected {overflow, count, word}
  function automatic logic [OUT_W+CW:0] model(input logic [IN_W-1:0] d,
                                             input logic [IN_W-1:0] m);
    logic [OUT_W-1:0] w = '0;
    int k = 0;
    int tot = 0;
    for (int i = 0; i < IN_W; i++) begin
      if (m[i]) begin
        if (k < OUT_W) begin
          w[k] = d[i];
          k++;
        end
        tot++;
      end
    end
    return {tot > OUT_W, CW'(k), w};
  endfunction

  task automatic compare(input string tag, input logic [OUT_W+CW:0] exp);
    n_vec++;
    if ({overflow, placed_cnt, packed_out} !== exp) begin
      n_bad++;
      $display("FAIL %s: got ov=%0b cnt=%0d word=%h, expected ov=%0b cnt=%0d word=%h",
               tag, overflow, placed_cnt, packed_out,
               exp[OUT_W+CW], exp[OUT_W+CW-1:OUT_W], exp[OUT_W-1:0]);
    end
  endtask

  // drive on a falling edge, result registered at the next rising edge
  task automatic apply(input string tag, input logic [IN_W-1:0] d,
                       input logic [IN_W-1:0] m);
    data_in = d;
    en_mask = m;
    @(negedge clk);
    compare(tag, model(d, m));
  endtask

  function automatic logic [IN_W-1:0] mask_with_n(input int n);
    logic [IN_W-1:0] m = '0;
    int placed = 0;
    while (placed < n) begin
      int idx = int'($urandom_range(IN_W-1, 0));
      if (!m[idx]) begin
        m[idx] = 1'b1;
        placed++;
      end
    end
    return m;
  endfunction

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [IN_W-1:0] d, m;
    logic [OUT_W+CW:0] ref_v;
    void'($urandom(32'd1234));
    data_in = 32'hFFFF_FFFF;
    en_mask = 32'hFFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    compare("R5 reset state", '0);
    rst = 1'b0;

    // R1 simple placements
    apply("R1 single high bit", 32'h8000_0000, 32'h8000_0000);
    apply("R1 alternating", 32'hAAAA_AAAA, 32'h5555_5555);
    apply("R1 nibble pattern", 32'h1234_5678, 32'h0F0F_00F0);
    // R3 sparse and empty masks
    apply("R3 empty mask", 32'hFFFF_FFFF, 32'h0);
    apply("R3 three bits", 32'hFFFF_FFFF, 32'h8001_0002);
    // R6 R7 boundary counts
    d = $urandom; apply("R7 fifteen set", d, mask_with_n(15));
    d = $urandom; apply("R6 exactly sixteen", d, mask_with_n(16));
    d = $urandom; apply("R6 seventeen", d, mask_with_n(17));
    // R2 all ones keeps the low half
    apply("R2 all enabled", 32'hC3A5_5A3C, 32'hFFFF_FFFF);
    apply("R2 upper dropped", 32'h0000_FFFF, 32'hFFFF_FFFF);

    // R8 disabled data has no effect
    for (int t = 0; t < 20; t++) begin
      d = $urandom;
      m = $urandom;
      ref_v = model(d, m);
      data_in = d ^ ~m;
      en_mask = m;
      @(negedge clk);
      compare("R8 disabled data ignored", ref_v);
    end

    // R4 outputs hold until the rising edge
    apply("R4 setup", 32'h0000_00FF, 32'h0000_00FF);
    ref_v = model(32'h0000_00FF, 32'h0000_00FF);
    data_in = 32'h0;
    en_mask = 32'hFFFF_FFFF;
    #5;
    compare("R4 held before edge", ref_v);
    @(negedge clk);
    compare("R4 updated after edge", model(32'h0, 32'hFFFF_FFFF));

    // R5 reset in the middle of traffic
    data_in = 32'hDEAD_BEEF;
    en_mask = 32'hFFFF_FFFF;
    rst = 1'b1;
    @(negedge clk);
    compare("R5 mid-run reset", '0);
    rst = 1'b0;

    // random traffic of varied density
    for (int t = 0; t < 3000; t++) begin
      d = $urandom;
      case (t % 4)
        0: m = $urandom & $urandom & $urandom;
        1: m = $urandom & $urandom;
        2: m = $urandom;
        default: m = $urandom | $urandom;
      endcase
      apply("R1 R2 R6 R7 random", d, m);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    done = 1'b1;
    $finish;
  end
endmodule